// File: doc/BRIEF.md
# DMA Write Snoop Unit for a Direct-Mapped Data Cache

This block keeps a small processor data cache coherent while an outside DMA master owns the system bus. The unit holds the cache's line state: a valid bit, an address tag and one data word per line. It watches every bus beat. When the DMA master owns the bus and writes an address that is present in the cache, the unit does one of two things. Under the invalidate policy it drops the line. Under the update policy it writes the DMA data into the line, and the line stays valid.

The processor side has one access port. A write installs a line: it sets the valid bit and loads the tag and the data word. A read returns the hit flag and the data one cycle later. A snoop action always wins over a processor write to the same line in the same cycle. In that case the processor write is dropped and flagged so that it can be issued again. A saturating counter of snoop hits and a one-cycle hit pulse make the snoop activity visible.

Top module: `dma_snoop_unit`

## Requirements
- R1: After reset every line is invalid, `hit_count` is 0, and `snp_hit` and `cpu_rvalid` are 0.
- R2: A processor write (`cpu_valid`=1, `cpu_write`=1) installs the line as valid with the tag and data of the write. A processor read (`cpu_valid`=1, `cpu_write`=0) raises `cpu_rvalid` one cycle later. In that cycle `cpu_rhit`=1 and `cpu_rdata` is the line data when the line is valid and the tags match. Otherwise `cpu_rhit`=0 and `cpu_rdata`=0.
- R3: A bus write made while `dma_owner`=0 changes no line, raises no `snp_hit` and does not change `hit_count`.
- R4: With `policy_update`=0, a snoop hit clears the valid bit of the matching line.
- R5: With `policy_update`=1, a snoop hit replaces the data of the matching line with `bus_wdata`, and the line stays valid with its tag unchanged.
- R6: Bus reads by the DMA master and bus writes that miss leave every line and `hit_count` unchanged. A miss is an invalid line or a tag mismatch.
- R7: The line index is address bits [5:2] and the tag is bits [31:6]. Bits [1:0] play no part in the index or the tag.
- R8: If a processor write targets the same line as a snoop hit in the same cycle, the snoop action is applied, the processor write is dropped, and `cpu_retry` is 1 in that cycle. A processor write to a different line takes effect alongside the snoop, with `cpu_retry`=0.
- R9: `snp_hit` is 1 in exactly the cycle after each snoop hit. `hit_count` rises by one per hit and saturates at 255.
- R10: A processor read in the same cycle as a snoop action on the same line returns the line state from before the snoop action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | A bus beat is present |
| bus_write | input | 1 | The beat is a write |
| dma_owner | input | 1 | The DMA master owns the bus |
| bus_addr | input | 32 | Beat byte address |
| bus_wdata | input | 32 | Beat write data |
| policy_update | input | 1 | 0: invalidate on hit, 1: update on hit |
| cpu_valid | input | 1 | Processor access request |
| cpu_write | input | 1 | Processor access is a line install |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor install data |
| cpu_retry | output | 1 | Processor write dropped in favour of the snoop |
| cpu_rvalid | output | 1 | Read result valid |
| cpu_rhit | output | 1 | Read hit |
| cpu_rdata | output | 32 | Read data, 0 on a miss |
| snp_hit | output | 1 | One-cycle pulse after a snoop hit |
| hit_count | output | 8 | Saturating snoop hit count |

## Verification
The snoop is driven with DMA writes that hit and with DMA writes that miss on the tag. These are followed by the same address written while the processor owns the bus, and by DMA reads of it. This separates a correct ownership and direction qualifier from one that reacts to any beat. Both policies are applied to valid lines and read back, which shows invalidation apart from a data update. A hit with nonzero byte-offset bits checks that the offset is ignored. Same-cycle collisions between a processor write and a snoop are tried on the same line and on different lines. A read is also issued in the same cycle as a snoop on its own line. Together these show the priority order and the pre-update read value. A long run of hits drives the counter into saturation.

// File: rtl/dma_snoop_pkg.sv
package dma_snoop_pkg;

  typedef enum logic [1:0] {
    SNP_NONE = 2'b00,
    SNP_INV  = 2'b01,
    SNP_UPD  = 2'b10
  } snp_act_e;

  function automatic snp_act_e pick_action(input logic hit, input logic upd_policy);
    if (!hit)           return SNP_NONE;
    else if (upd_policy) return SNP_UPD;
    else                return SNP_INV;
  endfunction

endpackage

// File: rtl/snoop_addr_split.sv
module snoop_addr_split #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  assign idx = addr[OFF_W +: IDX_W];
  assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/snoop_line_store.sv
module snoop_line_store
  import dma_snoop_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 32,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // snoop lookup and action
  input  logic [IDX_W-1:0]  snp_idx,
  output logic              snp_line_valid,
  output logic [TAG_W-1:0]  snp_line_tag,
  input  snp_act_e          snp_act,
  input  logic [DATA_W-1:0] snp_wdata,
  // processor lookup and install
  input  logic [IDX_W-1:0]  cpu_idx,
  output logic              cpu_line_valid,
  output logic [TAG_W-1:0]  cpu_line_tag,
  output logic [DATA_W-1:0] cpu_line_data,
  input  logic              cpu_wr_en,
  input  logic [TAG_W-1:0]  cpu_wr_tag,
  input  logic [DATA_W-1:0] cpu_wr_data
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  assign snp_line_valid = valid_q[snp_idx];
  assign snp_line_tag   = tag_q[snp_idx];
  assign cpu_line_valid = valid_q[cpu_idx];
  assign cpu_line_tag   = tag_q[cpu_idx];
  assign cpu_line_data  = data_q[cpu_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (snp_act != SNP_NONE && snp_idx == IDX_W'(i)) begin
          if (snp_act == SNP_INV) valid_q[i] <= 1'b0;
          else                    data_q[i]  <= snp_wdata;
        end else if (cpu_wr_en && cpu_idx == IDX_W'(i)) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= cpu_wr_tag;
          data_q[i]  <= cpu_wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/snoop_hit_counter.sv
module snoop_hit_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= sat_inc(count);
  end
endmodule

// File: rtl/dma_snoop_unit.sv
module dma_snoop_unit
  import dma_snoop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              dma_owner,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              policy_update,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_retry,
  output logic              cpu_rvalid,
  output logic              cpu_rhit,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              snp_hit,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [IDX_W-1:0]  bus_idx, cpu_idx;
  logic [TAG_W-1:0]  bus_tag, cpu_tag;
  logic              snp_line_valid, cpu_line_valid;
  logic [TAG_W-1:0]  snp_line_tag, cpu_line_tag;
  logic [DATA_W-1:0] cpu_line_data;

  // named internal events
  logic     dma_write_beat;
  logic     snoop_hit;
  snp_act_e snoop_act;
  logic     cpu_install_req;
  logic     cpu_read_req;
  logic     cpu_read_match;

  snoop_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_bus_split (
    .addr(bus_addr), .idx(bus_idx), .tag(bus_tag)
  );

  snoop_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_cpu_split (
    .addr(cpu_addr), .idx(cpu_idx), .tag(cpu_tag)
  );

  assign dma_write_beat  = dma_owner && bus_valid && bus_write;
  assign snoop_hit       = dma_write_beat && snp_line_valid && (snp_line_tag == bus_tag);
  assign snoop_act       = pick_action(snoop_hit, policy_update);
  assign cpu_install_req = cpu_valid && cpu_write;
  assign cpu_read_req    = cpu_valid && !cpu_write;
  assign cpu_read_match  = cpu_line_valid && (cpu_line_tag == cpu_tag);
  assign cpu_retry       = cpu_install_req && snoop_hit && (cpu_idx == bus_idx);

  snoop_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk            (clk),
    .rst_n          (rst_n),
    .snp_idx        (bus_idx),
    .snp_line_valid (snp_line_valid),
    .snp_line_tag   (snp_line_tag),
    .snp_act        (snoop_act),
    .snp_wdata      (bus_wdata),
    .cpu_idx        (cpu_idx),
    .cpu_line_valid (cpu_line_valid),
    .cpu_line_tag   (cpu_line_tag),
    .cpu_line_data  (cpu_line_data),
    .cpu_wr_en      (cpu_install_req),
    .cpu_wr_tag     (cpu_tag),
    .cpu_wr_data    (cpu_wdata)
  );

  snoop_hit_counter #(.CNT_W(CNT_W)) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (snoop_hit),
    .count (hit_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      cpu_rhit   <= 1'b0;
      cpu_rdata  <= '0;
      snp_hit    <= 1'b0;
    end else begin
      cpu_rvalid <= cpu_read_req;
      cpu_rhit   <= cpu_read_req && cpu_read_match;
      cpu_rdata  <= (cpu_read_req && cpu_read_match) ? cpu_line_data : '0;
      snp_hit    <= snoop_hit;
    end
  end
endmodule

// File: rtl/dma_snoop_checker.sv
module dma_snoop_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_owner,
  input logic             bus_valid,
  input logic             bus_write,
  input logic             cpu_valid,
  input logic             cpu_write,
  input logic             cpu_retry,
  input logic             cpu_rvalid,
  input logic             cpu_rhit,
  input logic             snoop_hit,
  input logic             snp_hit,
  input logic [CNT_W-1:0] hit_count
);
  p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write) |=> cpu_rvalid);

  p_rhit_within_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rhit |-> cpu_rvalid);

  p_snoop_needs_dma_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |-> (dma_owner && bus_valid && bus_write));

  p_retry_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_retry |-> (snoop_hit && cpu_valid && cpu_write));

  p_pulse_after_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit |=> snp_hit);

  p_no_pulse_without_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_hit |=> !snp_hit);

  p_count_steps_by_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_hit && !(&hit_count) |=> hit_count == CNT_W'($past(hit_count) + 1'b1));

  p_count_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !snoop_hit |=> $stable(hit_count));

  p_count_saturates_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&hit_count) |=> (&hit_count));
endmodule

bind dma_snoop_unit dma_snoop_checker #(.CNT_W(CNT_W)) u_snoop_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_owner  (dma_owner),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .cpu_valid  (cpu_valid),
  .cpu_write  (cpu_write),
  .cpu_retry  (cpu_retry),
  .cpu_rvalid (cpu_rvalid),
  .cpu_rhit   (cpu_rhit),
  .snoop_hit  (snoop_hit),
  .snp_hit    (snp_hit),
  .hit_count  (hit_count)
);

// File: tb/dma_snoop_unit_bench.sv
module dma_snoop_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 0, bus_write = 0, dma_owner = 0, policy_update = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic        cpu_valid = 0, cpu_write = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0;
  logic        cpu_retry, cpu_rvalid, cpu_rhit, snp_hit;
  logic [31:0] cpu_rdata;
  logic [7:0]  hit_count;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_snoop_unit u_dma_snoop_unit (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .dma_owner(dma_owner),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .policy_update(policy_update),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_retry(cpu_retry), .cpu_rvalid(cpu_rvalid), .cpu_rhit(cpu_rhit), .cpu_rdata(cpu_rdata),
    .snp_hit(snp_hit), .hit_count(hit_count)
  );

  // behavioural reference model
  bit          m_valid [16];
  int unsigned m_tag   [16];
  logic [31:0] m_data  [16];
  int          m_count;
  bit          m_snp, m_rv, m_rh;
  logic [31:0] m_rd;

  function automatic int line_of(input logic [31:0] a);
    return int'(a / 4) % 16;
  endfunction

  function automatic int unsigned tag_of(input logic [31:0] a);
    return int'(a / 64);
  endfunction

  function automatic logic [31:0] mk(input int unsigned tag, input int line, input int off);
    return tag * 64 + line * 4 + off;
  endfunction

  function automatic bit model_hit();
    return dma_owner && bus_valid && bus_write && m_valid[line_of(bus_addr)] &&
           m_tag[line_of(bus_addr)] == tag_of(bus_addr);
  endfunction

  function automatic bit model_retry();
    return cpu_valid && cpu_write && model_hit() && line_of(cpu_addr) == line_of(bus_addr);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[k]) begin m_valid[k] = 0; m_tag[k] = 0; m_data[k] = 0; end
      m_count = 0; m_snp = 0; m_rv = 0; m_rh = 0; m_rd = 0;
    end else begin
      bit hit, drop;
      int bl, cl;
      hit  = model_hit();
      drop = model_retry();
      bl = line_of(bus_addr);
      cl = line_of(cpu_addr);
      m_rv = cpu_valid && !cpu_write;
      m_rh = m_rv && m_valid[cl] && m_tag[cl] == tag_of(cpu_addr);
      m_rd = m_rh ? m_data[cl] : 32'h0;
      m_snp = hit;
      if (hit && m_count < 255) m_count++;
      if (hit) begin
        if (policy_update) m_data[bl] = bus_wdata;
        else               m_valid[bl] = 0;
      end
      if (cpu_valid && cpu_write && !drop) begin
        m_valid[cl] = 1; m_tag[cl] = tag_of(cpu_addr); m_data[cl] = cpu_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // outputs captured at the last step, for directed checks
  logic        s_rvalid, s_rhit;
  logic [31:0] s_rdata;
  logic [7:0]  s_count;

  task automatic step(input bit bv, input bit bw, input bit own, input logic [31:0] ba,
                      input logic [31:0] bd, input bit pol,
                      input bit cv, input bit cw, input logic [31:0] ca, input logic [31:0] cd);
    @(negedge clk);
    chk(cpu_rvalid == m_rv, "R2 rvalid", 32'(cpu_rvalid), 32'(m_rv));
    chk(cpu_rhit == m_rh, "R2 rhit", 32'(cpu_rhit), 32'(m_rh));
    chk(cpu_rdata == m_rd, "R2 rdata", cpu_rdata, m_rd);
    chk(snp_hit == m_snp, "R9 snp_hit", 32'(snp_hit), 32'(m_snp));
    chk(int'(hit_count) == m_count, "R9 hit_count", 32'(hit_count), 32'(m_count));
    s_rvalid = cpu_rvalid; s_rhit = cpu_rhit; s_rdata = cpu_rdata; s_count = hit_count;
    bus_valid = bv; bus_write = bw; dma_owner = own; bus_addr = ba; bus_wdata = bd;
    policy_update = pol; cpu_valid = cv; cpu_write = cw; cpu_addr = ca; cpu_wdata = cd;
    #1;
    chk(cpu_retry == model_retry(), "R8 retry", 32'(cpu_retry), 32'(model_retry()));
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic install(input logic [31:0] a, input logic [31:0] d);
    step(0, 0, 0, 0, 0, 0, 1, 1, a, d);
  endtask

  task automatic dma(input bit wr, input bit own, input logic [31:0] a, input logic [31:0] d, input bit pol);
    step(1, wr, own, a, d, pol, 0, 0, 0, 0);
  endtask

  task automatic expect_read(input logic [31:0] a, input bit hit, input logic [31:0] d, input string req);
    step(0, 0, 0, 0, 0, 0, 1, 0, a, 0);
    idle();
    chk(s_rvalid == 1'b1, req, 32'(s_rvalid), 32'h1);
    chk(s_rhit == hit, req, 32'(s_rhit), 32'(hit));
    chk(s_rdata == d, req, s_rdata, d);
  endtask

  task automatic expect_count(input int n, input string req);
    idle();
    chk(int'(s_count) == n, req, 32'(s_count), 32'(n));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    chk(hit_count == 0, "R1 count", 32'(hit_count), 0);
    chk(cpu_rvalid == 0 && snp_hit == 0, "R1 flags", 32'({cpu_rvalid, snp_hit}), 0);
    expect_read(mk(5, 3, 0), 0, 0, "R1 line invalid");

    // R2: install and read back, tag mismatch misses
    install(mk(5, 3, 0), 32'hAAAA_0003);
    install(mk(7, 9, 0), 32'hBBBB_0009);
    expect_read(mk(5, 3, 0), 1, 32'hAAAA_0003, "R2 hit");
    expect_read(mk(7, 9, 0), 1, 32'hBBBB_0009, "R2 hit second line");
    expect_read(mk(6, 3, 0), 0, 0, "R2 tag mismatch");

    // R3: processor-owned bus write ignored
    dma(1, 0, mk(5, 3, 0), 32'h1111_1111, 0);
    expect_read(mk(5, 3, 0), 1, 32'hAAAA_0003, "R3 line untouched");
    expect_count(0, "R3 count");

    // R6: DMA read and DMA write miss ignored
    dma(0, 1, mk(5, 3, 0), 32'h2222_2222, 0);
    dma(1, 1, mk(6, 3, 0), 32'h3333_3333, 0);
    expect_read(mk(5, 3, 0), 1, 32'hAAAA_0003, "R6 line untouched");
    expect_count(0, "R6 count");

    // R5 + R7: update policy, offset bits set
    dma(1, 1, mk(5, 3, 3), 32'h0000_1234, 1);
    expect_read(mk(5, 3, 0), 1, 32'h0000_1234, "R5 R7 updated");
    expect_count(1, "R5 count");

    // R4: invalidate policy
    dma(1, 1, mk(7, 9, 0), 32'h4444_4444, 0);
    expect_read(mk(7, 9, 0), 0, 0, "R4 invalidated");
    expect_count(2, "R4 count");

    // R8: same-line collision, then different-line collision
    install(mk(7, 9, 0), 32'hBBBB_0009);
    step(1, 1, 1, mk(5, 3, 0), 0, 0, 1, 1, mk(8, 3, 0), 32'h5555_5555);
    chk(cpu_retry == 1'b1, "R8 same line retry", 32'(cpu_retry), 1);
    expect_read(mk(8, 3, 0), 0, 0, "R8 cpu write dropped");
    expect_read(mk(5, 3, 0), 0, 0, "R8 snoop applied");
    step(1, 1, 1, mk(7, 9, 0), 32'h6666_6666, 1, 1, 1, mk(2, 1, 0), 32'h7777_7777);
    chk(cpu_retry == 1'b0, "R8 other line no retry", 32'(cpu_retry), 0);
    expect_read(mk(7, 9, 0), 1, 32'h6666_6666, "R8 snoop update");
    expect_read(mk(2, 1, 0), 1, 32'h7777_7777, "R8 cpu install");

    // R10: read concurrent with snoop invalidate on same line
    step(1, 1, 1, mk(7, 9, 0), 0, 0, 1, 0, mk(7, 9, 0), 0);
    idle();
    chk(s_rhit == 1'b1 && s_rdata == 32'h6666_6666, "R10 pre-snoop read", s_rdata, 32'h6666_6666);
    expect_read(mk(7, 9, 0), 0, 0, "R10 then invalid");
    expect_count(5, "R9 count before saturation");

    // R9: saturation
    install(mk(1, 0, 0), 32'h0);
    for (int i = 0; i < 260; i++) dma(1, 1, mk(1, 0, 0), 32'(i), 1);
    expect_count(255, "R9 saturated");
    expect_read(mk(1, 0, 0), 1, 32'd259, "R5 last update");
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule